// File: doc/BRIEF.md
# Voted Branch Clock Gate

This block gates one branch of a clock tree that hangs off a root clock generator. The root delivers a clock-enable strobe, `root_ce`. The block passes that strobe on as `gated_ce` only while the branch is requested. A request comes from either of two sources: a local enable bit in the branch control register, or one assigned bit of a shared vote register. Other agents may own the remaining bits of the vote register, and those bits do not affect this branch. A separate reset register drives a block reset output for the peripheral that the branch feeds.

A request does not act on the gate at once. It first passes through a synchroniser. The gate then changes state only between root strobes, so every strobe leaves the block whole or not at all. Software reads a clock-off flag in the branch control register. The flag shows the gate state that is actually in force, not the state that was requested. After enabling the branch, software polls the flag until it reads 0, and only then uses the peripheral. While the block reset is set, the gate is closed and the flag reads 1.

Top module: `bcg_branch_gate`

## Requirements
- R1: After reset, the branch control register reads 0x8000_0000: local enable 0 and clock-off flag 1. The vote register and the reset register read 0, and both `gated_ce` and `blk_rst` are 0.
- R2: Bit 0 of the branch control register (address 0) is the local enable. It reads back as written, and setting it opens the gate.
- R3: In the vote register (address 1), only bit VOTE_BIT (default 10) requests this branch. All bits are stored and read back, and any other set bit leaves the gate closed.
- R4: Bit 31 of the branch control register is a read-only clock-off flag, 1 while the gate is closed. Writes to bit 31 or to bits 30..1 have no effect, and bits 30..1 read 0.
- R5: The clock-off flag changes only after the synchroniser. A read issued in any of the SYNC_STAGES+1 cycles that follow the enabling or disabling write returns the old value of the flag. The next read returns the new value.
- R6: While the gate is open, `gated_ce` equals `root_ce` delayed by one clock. While the gate is closed, `gated_ce` is 0.
- R7: The gate changes state only in a cycle where `root_ce` is 0. A request that changes during a long strobe takes effect only after that strobe ends, and the strobe passes through unshortened.
- R8: Bit 0 of the reset register (address 2) drives `blk_rst` from the cycle after the write. While it is set, `gated_ce` is 0 and the clock-off flag reads 1, whatever the enables hold. After it is cleared, the branch reopens through the synchroniser.
- R9: A read of address 3 returns 0. Read data appears on `bus_rdata` one clock after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_ce | input | 1 | Clock-enable strobe from the root generator |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 branch control, 1 vote, 2 block reset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| gated_ce | output | 1 | Gated clock-enable strobe to the branch |
| blk_rst | output | 1 | Block reset to the peripheral |

## Verification
The critical coincidence is a request change that arrives while a root strobe is in progress. The bench holds `root_ce` high, clears the local enable through the bus, and lets the synchroniser settle while the strobe is still high. It then confirms three things. `gated_ce` stays high for the whole strobe. The clock-off flag still reads 0 during the strobe. The gate closes only at the low cycle that follows, so the next strobe is fully suppressed. A second coincidence, block reset set while the branch is open and strobing, is judged by checking that the output is masked at once while the flag reads 1.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADR_BRANCH = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_VOTE   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_BLKRST = 2'd2;
  localparam int EN_BIT  = 0;
  localparam int ARS_BIT = 0;
endpackage

// File: rtl/bcg_regs.sv
module bcg_regs
  import bcg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int VOTE_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              off_flag,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              branch_req,
  output logic              blk_rst
);
  localparam int OFF_BIT = DATA_W - 1;

  logic              local_en;
  logic [DATA_W-1:0] vote_q;
  logic              ares_q;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      local_en <= 1'b0;
      vote_q   <= '0;
      ares_q   <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADR_BRANCH: local_en <= bus_wdata[EN_BIT];
        ADR_VOTE:   vote_q   <= bus_wdata;
        ADR_BLKRST: ares_q   <= bus_wdata[ARS_BIT];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADR_BRANCH: begin
        rd_mux[EN_BIT]  = local_en;
        rd_mux[OFF_BIT] = off_flag;
      end
      ADR_VOTE:   rd_mux = vote_q;
      ADR_BLKRST: rd_mux[ARS_BIT] = ares_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign branch_req = local_en | vote_q[VOTE_BIT];
  assign blk_rst    = ares_q;

  // R8: a written reset bit reaches the output on the next cycle
  a_r8_ares_write: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr) && ($past(bus_addr) == ADR_BLKRST) |-> blk_rst == $past(bus_wdata[ARS_BIT]));
endmodule

// File: rtl/bcg_sync.sv
module bcg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bcg_gate.sv
module bcg_gate (
  input  logic clk,
  input  logic rst,
  input  logic root_ce,
  input  logic req_sync,
  input  logic blk_rst,
  output logic gate_open,
  output logic gated_ce
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_open <= 1'b0;
      gated_ce  <= 1'b0;
    end else begin
      if (!root_ce) gate_open <= req_sync;
      gated_ce <= root_ce & gate_open & ~blk_rst;
    end
  end

  // R6: no output strobe without a root strobe one cycle earlier
  a_r6_needs_root: assert property (@(posedge clk) disable iff (rst)
    gated_ce |-> $past(root_ce));

  // R7: gate state moves only between root strobes
  a_r7_open_between_pulses: assert property (@(posedge clk) disable iff (rst)
    !$stable(gate_open) |-> !$past(root_ce));
endmodule

// File: rtl/bcg_branch_gate.sv
module bcg_branch_gate
  import bcg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int VOTE_BIT    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              root_ce,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              gated_ce,
  output logic              blk_rst
);
  logic branch_req;
  logic req_sync;
  logic gate_open;
  logic off_flag;

  bcg_regs #(.DATA_W(DATA_W), .VOTE_BIT(VOTE_BIT)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .off_flag(off_flag),
    .bus_rdata(bus_rdata), .branch_req(branch_req), .blk_rst(blk_rst)
  );

  bcg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(branch_req & ~blk_rst), .q(req_sync)
  );

  bcg_gate u_gate (
    .clk(clk), .rst(rst), .root_ce(root_ce), .req_sync(req_sync),
    .blk_rst(blk_rst), .gate_open(gate_open), .gated_ce(gated_ce)
  );

  assign off_flag = ~gate_open | blk_rst;

  // R8: reset held in the previous cycle masks the output
  a_r8_rst_masks: assert property (@(posedge clk) disable iff (rst)
    $past(blk_rst) |-> !gated_ce);

  // R7: a strobe is never cut short except by block reset
  a_r7_no_partial: assert property (@(posedge clk) disable iff (rst)
    $fell(gated_ce) |-> !$past(root_ce) || $past(blk_rst));

  // R1: first cycle after reset shows a closed gate
  a_r1_reset_closed: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> off_flag && !gated_ce && !blk_rst);
endmodule

// File: tb/tb_bcg_branch_gate.sv
`timescale 1ns/1ps
module tb_bcg_branch_gate;
  localparam int DW = 32;
  localparam int VB = 10;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic root_ce = 1'b0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic gated_ce;
  logic blk_rst;

  int checks = 0;
  int failures = 0;

  localparam logic [DW-1:0] OFF = 32'h8000_0000;

  bcg_branch_gate #(.DATA_W(DW), .VOTE_BIT(VB), .SYNC_STAGES(SS)) dut (
    .clk(clk), .rst(rst), .root_ce(root_ce), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gated_ce(gated_ce), .blk_rst(blk_rst)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic step(input logic v, input logic exp, input string req);
    root_ce = v;
    @(posedge clk); @(negedge clk);
    chk(req, {31'b0, gated_ce}, {31'b0, exp});
  endtask

  task automatic t_reset_state;
    logic [DW-1:0] d;
    chk("R1 gated", {31'b0, gated_ce}, 32'd0);
    chk("R1 blk_rst", {31'b0, blk_rst}, 32'd0);
    rd(2'd0, d); chk("R1 ctrl", d, OFF);
    rd(2'd1, d); chk("R1 vote", d, 32'd0);
    rd(2'd2, d); chk("R1 rstreg", d, 32'd0);
  endtask

  task automatic t_latency;
    logic [DW-1:0] d;
    wr(2'd0, 32'd1);
    for (int i = 0; i <= SS; i++) begin
      rd(2'd0, d); chk("R5 on-window", d, OFF | 32'd1);
    end
    rd(2'd0, d); chk("R2 R5 open", d, 32'd1);
    wr(2'd0, 32'd0);
    for (int i = 0; i <= SS; i++) begin
      rd(2'd0, d); chk("R5 off-window", d, 32'd0);
    end
    rd(2'd0, d); chk("R5 closed", d, OFF);
  endtask

  task automatic t_status_ro;
    logic [DW-1:0] d;
    wr(2'd0, OFF);
    rd(2'd0, d); chk("R4 bit31 write", d, OFF);
    idle(4);
    rd(2'd0, d); chk("R4 stays closed", d, OFF);
    wr(2'd0, 32'hFFFF_FFFF);
    idle(4);
    rd(2'd0, d); chk("R4 mid bits zero", d, 32'd1);
    wr(2'd0, 32'd0);
    idle(4);
  endtask

  task automatic t_vote;
    logic [DW-1:0] d;
    wr(2'd1, ~(32'd1 << VB));
    idle(4);
    rd(2'd0, d); chk("R3 other bits", d, OFF);
    rd(2'd1, d); chk("R3 vote readback", d, ~(32'd1 << VB));
    wr(2'd1, 32'd1 << VB);
    idle(4);
    rd(2'd0, d); chk("R3 vote opens", d, 32'd0);
    wr(2'd1, 32'd0);
    idle(4);
    rd(2'd0, d); chk("R3 vote clears", d, OFF);
  endtask

  task automatic t_pass;
    step(1'b1, 1'b0, "R6 closed a");
    step(1'b0, 1'b0, "R6 closed b");
    step(1'b1, 1'b0, "R6 closed c");
    step(1'b0, 1'b0, "R6 closed d");
    wr(2'd0, 32'd1);
    idle(4);
    step(1'b1, 1'b1, "R6 open a");
    step(1'b0, 1'b0, "R6 open b");
    step(1'b1, 1'b1, "R6 open c");
    step(1'b1, 1'b1, "R6 open d");
    step(1'b0, 1'b0, "R6 open e");
  endtask

  task automatic t_defer;
    logic [DW-1:0] d;
    step(1'b1, 1'b1, "R7 strobe start");
    wr(2'd0, 32'd0);
    chk("R7 held after write", {31'b0, gated_ce}, 32'd1);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, "R7 strobe intact");
    rd(2'd0, d); chk("R7 flag deferred", d, 32'd0);
    step(1'b0, 1'b0, "R7 strobe end");
    step(1'b1, 1'b0, "R7 next suppressed");
    step(1'b0, 1'b0, "R7 low");
    rd(2'd0, d); chk("R7 closed", d, OFF);
  endtask

  task automatic t_block_reset;
    logic [DW-1:0] d;
    wr(2'd0, 32'd1);
    idle(4);
    rd(2'd0, d); chk("R8 pre open", d, 32'd1);
    root_ce = 1'b1;
    wr(2'd2, 32'd1);
    chk("R8 blk_rst set", {31'b0, blk_rst}, 32'd1);
    step(1'b1, 1'b0, "R8 masked");
    rd(2'd0, d); chk("R8 flag forced", d, OFF | 32'd1);
    step(1'b0, 1'b0, "R8 low");
    rd(2'd2, d); chk("R8 rstreg", d, 32'd1);
    wr(2'd2, 32'd0);
    chk("R8 blk_rst clear", {31'b0, blk_rst}, 32'd0);
    idle(4);
    rd(2'd0, d); chk("R8 reopened", d, 32'd1);
    step(1'b1, 1'b1, "R8 passes again");
    step(1'b0, 1'b0, "R8 end");
  endtask

  task automatic t_unmapped;
    logic [DW-1:0] d;
    rd(2'd3, d); chk("R9 unmapped", d, 32'd0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_latency();
    t_status_ro();
    t_vote();
    t_pass();
    t_defer();
    t_block_reset();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule